// File: doc/BRIEF.md
# Cascadable Registered ALU Datapath

This block is a parameterised arithmetic and logic datapath, 16 bits wide by default. A 5-bit function code selects one of 32 operations: 19 arithmetic and 13 logical. Each operand has its own input register with an active-low load strobe. This lets both operands arrive one after the other over a single shared bus. A single control bypasses both operand registers, so the ALU can also work straight from the input buses.

The ALU output feeds a result register, which has its own active-low load strobe and its own bypass. The registered result can be fed back in place of operand A, operand B, or both. This supports running sums and chained operations.

Sign, carry-out, overflow and zero flags travel with the result. A carry input takes part in every arithmetic function, so several blocks can be chained into a wider word. An output enable forces the result bus to zero without disturbing the flags.

Top module: `casc_alu`

## Requirements
- R1: A synchronous, active-high reset clears both operand registers and the result register. After reset, with the result register selected, the result reads 0, the zero flag reads 1, and the sign, carry and overflow flags read 0.
- R2: On a rising clock edge, an operand register loads its input only while its active-low load strobe is low; otherwise it holds. One bus driven onto both inputs can fill A and then B on successive cycles.
- R3: While the operand bypass is high, the ALU uses the A and B inputs directly in the same cycle, with no clock edge needed.
- R4: The result register loads the ALU result, carry and overflow on a rising edge only while its active-low load strobe is low; otherwise all three hold.
- R5: While the result bypass is high, the result and all flags show the combinational ALU output.
- R6: When the A feedback select is high, the registered result replaces operand A. When the B feedback select is high, it replaces operand B. With both high, it replaces both operands.
- R7: Codes 0x00 to 0x12 compute, in code order: A+B+Cin, A+~B+Cin, ~A+B+Cin, A+Cin, B+Cin, ~A+Cin, ~B+Cin, A+A+Cin, B+B+Cin, A+ones+Cin, B+ones+Cin, ~A+~B+Cin, A+~B+1, ~A+B+1, A+B, 0, A+1, B+1, ~A+1. All results are taken modulo 2^WIDTH.
- R8: For arithmetic codes, the carry flag is the carry out of the top bit of the addition above. The overflow flag is set when the signed sum of the two addends plus the carry-in lies outside the two's-complement range. The sign flag is the result's top bit.
- R9: Codes 0x13 to 0x1F compute, in code order: A&B, A|B, A^B, ~(A^B), ~(A&B), ~(A|B), ~A, ~B, A, B, all ones, all zeros, A&~B. For these codes the carry and overflow flags are 0 and the sign flag is the result's top bit.
- R10: The zero flag is 1 exactly when every bit of the selected result, taken before output gating, is 0.
- R11: While the output enable is low, the result bus reads 0 and the flags are unaffected.
- R12: A carry-out fed into the carry-in of the next, more significant slice produces the correct wider sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | WIDTH | Operand A bus |
| bIn | input | WIDTH | Operand B bus |
| fnSel | input | 5 | Function code |
| carryIn | input | 1 | Carry into the least significant bit |
| loadAN | input | 1 | Active-low load strobe of the A register |
| loadBN | input | 1 | Active-low load strobe of the B register |
| loadFN | input | 1 | Active-low load strobe of the result register |
| passOperands | input | 1 | Bypass both operand registers |
| passResult | input | 1 | Bypass the result register |
| fbToA | input | 1 | Registered result replaces operand A |
| fbToB | input | 1 | Registered result replaces operand B |
| outEn | input | 1 | Output enable; low forces the result bus to 0 |
| resOut | output | WIDTH | Result bus |
| negFlag | output | 1 | Sign of result |
| carryOut | output | 1 | Carry out of the top bit |
| ovfFlag | output | 1 | Two's-complement overflow |
| zeroFlag | output | 1 | Result is all zeros |

## Verification
The bench builds a 4-bit instance and sweeps every function code against every A value, every B value and both carry-in values with both bypasses set. This separates each of the 32 functions from its neighbours and exposes wrong carry and overflow corners at the signed range edges.

Directed sequences then cover the registered paths:
- loading both operands from one shared bus, which tells a load from a hold;
- a running sum through A feedback until it wraps, which tells feedback from the external operand;
- a doubling with both feedback selects high;
- a held result register;
- output gating.

A two-slice 8-bit addition confirms the carry chain.

// File: rtl/casc_alu_pkg.sv
package casc_alu_pkg;
  localparam int FN_BITS = 5;

  typedef enum logic [2:0] {X_A, X_NA, X_B, X_NB, X_ZERO} xSrcT;
  typedef enum logic [2:0] {Y_B, Y_NB, Y_A, Y_ZERO, Y_ONES} ySrcT;
  typedef enum logic [1:0] {CI_EXT, CI_ONE, CI_ZERO} cinSrcT;
  typedef enum logic [3:0] {
    L_AND, L_OR, L_XOR, L_XNOR, L_NAND, L_NOR, L_NOTA, L_NOTB,
    L_PASSA, L_PASSB, L_ONES, L_ZEROS, L_ANDNB
  } logicOpT;

  typedef struct packed {
    logic    isLogic;
    xSrcT    xSrc;
    ySrcT    ySrc;
    cinSrcT  cinSrc;
    logicOpT lop;
  } aluCtlT;

  typedef struct packed {
    logic loadA;
    logic loadB;
    logic loadF;
    logic bypassOps;
    logic bypassRes;
    logic fbA;
    logic fbB;
    logic outEn;
  } regStrobeT;
endpackage

// File: rtl/casc_alu_ctrl.sv
module casc_alu_ctrl
  import casc_alu_pkg::*;
(
  input  logic [FN_BITS-1:0] fnSel,
  input  logic               loadAN,
  input  logic               loadBN,
  input  logic               loadFN,
  input  logic               passOperands,
  input  logic               passResult,
  input  logic               fbToA,
  input  logic               fbToB,
  input  logic               outEn,
  output aluCtlT             aluCtl,
  output regStrobeT          strobes
);
  // register strobes: active-low loads turned into active-high strobes
  always_comb begin
    strobes.loadA     = ~loadAN;
    strobes.loadB     = ~loadBN;
    strobes.loadF     = ~loadFN;
    strobes.bypassOps = passOperands;
    strobes.bypassRes = passResult;
    strobes.fbA       = fbToA;
    strobes.fbB       = fbToB;
    strobes.outEn     = outEn;
  end

  // function decode
  always_comb begin
    aluCtl.isLogic = 1'b0;
    aluCtl.xSrc    = X_A;
    aluCtl.ySrc    = Y_B;
    aluCtl.cinSrc  = CI_EXT;
    aluCtl.lop     = L_AND;
    case (fnSel)
      5'h00: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_B;    end
      5'h01: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_NB;   end
      5'h02: begin aluCtl.xSrc = X_NA;   aluCtl.ySrc = Y_B;    end
      5'h03: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_ZERO; end
      5'h04: begin aluCtl.xSrc = X_B;    aluCtl.ySrc = Y_ZERO; end
      5'h05: begin aluCtl.xSrc = X_NA;   aluCtl.ySrc = Y_ZERO; end
      5'h06: begin aluCtl.xSrc = X_NB;   aluCtl.ySrc = Y_ZERO; end
      5'h07: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_A;    end
      5'h08: begin aluCtl.xSrc = X_B;    aluCtl.ySrc = Y_B;    end
      5'h09: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_ONES; end
      5'h0A: begin aluCtl.xSrc = X_B;    aluCtl.ySrc = Y_ONES; end
      5'h0B: begin aluCtl.xSrc = X_NA;   aluCtl.ySrc = Y_NB;   end
      5'h0C: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_NB;   aluCtl.cinSrc = CI_ONE;  end
      5'h0D: begin aluCtl.xSrc = X_NA;   aluCtl.ySrc = Y_B;    aluCtl.cinSrc = CI_ONE;  end
      5'h0E: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_B;    aluCtl.cinSrc = CI_ZERO; end
      5'h0F: begin aluCtl.xSrc = X_ZERO; aluCtl.ySrc = Y_ZERO; aluCtl.cinSrc = CI_ZERO; end
      5'h10: begin aluCtl.xSrc = X_A;    aluCtl.ySrc = Y_ZERO; aluCtl.cinSrc = CI_ONE;  end
      5'h11: begin aluCtl.xSrc = X_B;    aluCtl.ySrc = Y_ZERO; aluCtl.cinSrc = CI_ONE;  end
      5'h12: begin aluCtl.xSrc = X_NA;   aluCtl.ySrc = Y_ZERO; aluCtl.cinSrc = CI_ONE;  end
      5'h13: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_AND;   end
      5'h14: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_OR;    end
      5'h15: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_XOR;   end
      5'h16: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_XNOR;  end
      5'h17: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_NAND;  end
      5'h18: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_NOR;   end
      5'h19: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_NOTA;  end
      5'h1A: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_NOTB;  end
      5'h1B: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_PASSA; end
      5'h1C: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_PASSB; end
      5'h1D: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_ONES;  end
      5'h1E: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_ZEROS; end
      default: begin aluCtl.isLogic = 1'b1; aluCtl.lop = L_ANDNB; end
    endcase
  end
endmodule

// File: rtl/casc_alu_dp.sv
module casc_alu_dp
  import casc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  input  aluCtlT           aluCtl,
  input  regStrobeT        strobes,
  output logic [WIDTH-1:0] resOut,
  output logic             negFlag,
  output logic             carryOut,
  output logic             ovfFlag,
  output logic             zeroFlag
);
  localparam int SUM_W = WIDTH + 1;
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] aReg, bReg, fReg;
  logic             cReg, vReg;
  logic [WIDTH-1:0] opA, opB, addX, addY, logicRes, aluRes, fPath;
  logic [SUM_W-1:0] sum;
  logic             cinBit, aluC, aluV, cPath, vPath;

  // operand registers
  always_ff @(posedge clk) begin
    if (rst) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      if (strobes.loadA) aReg <= aIn;
      if (strobes.loadB) bReg <= bIn;
    end
  end

  // operand selection: feedback beats bypass beats register
  always_comb begin
    if (strobes.fbA)            opA = fReg;
    else if (strobes.bypassOps) opA = aIn;
    else                        opA = aReg;
    if (strobes.fbB)            opB = fReg;
    else if (strobes.bypassOps) opB = bIn;
    else                        opB = bReg;
  end

  // adder inputs
  always_comb begin
    case (aluCtl.xSrc)
      X_A:     addX = opA;
      X_NA:    addX = ~opA;
      X_B:     addX = opB;
      X_NB:    addX = ~opB;
      default: addX = '0;
    endcase
    case (aluCtl.ySrc)
      Y_B:     addY = opB;
      Y_NB:    addY = ~opB;
      Y_A:     addY = opA;
      Y_ONES:  addY = ALL_ONES;
      default: addY = '0;
    endcase
    case (aluCtl.cinSrc)
      CI_EXT:  cinBit = carryIn;
      CI_ONE:  cinBit = 1'b1;
      default: cinBit = 1'b0;
    endcase
  end

  assign sum = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, cinBit};

  // logic unit
  always_comb begin
    case (aluCtl.lop)
      L_AND:   logicRes = opA & opB;
      L_OR:    logicRes = opA | opB;
      L_XOR:   logicRes = opA ^ opB;
      L_XNOR:  logicRes = ~(opA ^ opB);
      L_NAND:  logicRes = ~(opA & opB);
      L_NOR:   logicRes = ~(opA | opB);
      L_NOTA:  logicRes = ~opA;
      L_NOTB:  logicRes = ~opB;
      L_PASSA: logicRes = opA;
      L_PASSB: logicRes = opB;
      L_ONES:  logicRes = ALL_ONES;
      L_ZEROS: logicRes = '0;
      default: logicRes = opA & ~opB;
    endcase
  end

  // result and arithmetic flags
  always_comb begin
    if (aluCtl.isLogic) begin
      aluRes = logicRes;
      aluC   = 1'b0;
      aluV   = 1'b0;
    end else begin
      aluRes = sum[WIDTH-1:0];
      aluC   = sum[WIDTH];
      aluV   = (addX[WIDTH-1] == addY[WIDTH-1]) && (sum[WIDTH-1] != addX[WIDTH-1]);
    end
  end

  // result register
  always_ff @(posedge clk) begin
    if (rst) begin
      fReg <= '0;
      cReg <= 1'b0;
      vReg <= 1'b0;
    end else if (strobes.loadF) begin
      fReg <= aluRes;
      cReg <= aluC;
      vReg <= aluV;
    end
  end

  assign fPath = strobes.bypassRes ? aluRes : fReg;
  assign cPath = strobes.bypassRes ? aluC   : cReg;
  assign vPath = strobes.bypassRes ? aluV   : vReg;

  assign resOut   = strobes.outEn ? fPath : '0;
  assign negFlag  = fPath[WIDTH-1];
  assign zeroFlag = (fPath == '0);
  assign carryOut = cPath;
  assign ovfFlag  = vPath;

  // R2: operand registers load and hold
  assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadA |=> (aReg == $past(aIn)));
  assert_hold_a_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadA |=> $stable(aReg));
  assert_hold_b_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadB |=> $stable(bReg));
  // R4: result register hold
  assert_hold_f_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadF |=> ($stable(fReg) && $stable(cReg) && $stable(vReg)));
  // R9: logical functions leave carry and overflow clear
  assert_logic_flags_R9: assert property (@(posedge clk) disable iff (rst)
    (aluCtl.isLogic && strobes.bypassRes) |-> (!carryOut && !ovfFlag));
endmodule

// File: rtl/casc_alu.sv
module casc_alu
  import casc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   aIn,
  input  logic [WIDTH-1:0]   bIn,
  input  logic [FN_BITS-1:0] fnSel,
  input  logic               carryIn,
  input  logic               loadAN,
  input  logic               loadBN,
  input  logic               loadFN,
  input  logic               passOperands,
  input  logic               passResult,
  input  logic               fbToA,
  input  logic               fbToB,
  input  logic               outEn,
  output logic [WIDTH-1:0]   resOut,
  output logic               negFlag,
  output logic               carryOut,
  output logic               ovfFlag,
  output logic               zeroFlag
);
  aluCtlT    aluCtl;
  regStrobeT strobes;

  casc_alu_ctrl u_ctrl (
    .fnSel(fnSel), .loadAN(loadAN), .loadBN(loadBN), .loadFN(loadFN),
    .passOperands(passOperands), .passResult(passResult),
    .fbToA(fbToA), .fbToB(fbToB), .outEn(outEn),
    .aluCtl(aluCtl), .strobes(strobes)
  );

  casc_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .carryIn(carryIn),
    .aluCtl(aluCtl), .strobes(strobes),
    .resOut(resOut), .negFlag(negFlag), .carryOut(carryOut),
    .ovfFlag(ovfFlag), .zeroFlag(zeroFlag)
  );

  // R11: disabled output reads zero
  assert_out_gate_R11: assert property (@(posedge clk) disable iff (rst)
    !outEn |-> (resOut == '0));
endmodule

// File: tb/sim_casc_alu.sv
module sim_casc_alu;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [4:0] fnSel = '0;
  logic carryIn = 1'b0, loadAN = 1'b1, loadBN = 1'b1, loadFN = 1'b1;
  logic passOperands = 1'b0, passResult = 1'b0, fbToA = 1'b0, fbToB = 1'b0, outEn = 1'b1;
  logic [W-1:0] resOut;
  logic negFlag, carryOut, ovfFlag, zeroFlag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  casc_alu #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .fnSel(fnSel), .carryIn(carryIn),
    .loadAN(loadAN), .loadBN(loadBN), .loadFN(loadFN),
    .passOperands(passOperands), .passResult(passResult),
    .fbToA(fbToA), .fbToB(fbToB), .outEn(outEn),
    .resOut(resOut), .negFlag(negFlag), .carryOut(carryOut),
    .ovfFlag(ovfFlag), .zeroFlag(zeroFlag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic int sgn(input int v);
    return (v > (M >> 1)) ? v - (M + 1) : v;
  endfunction

  // expected {res, carry, ovf} from the requirement tables
  task automatic model(input int op, input int a, input int b, input int c,
                       output int res, output int cy, output int ov);
    int x, y, ci, s, ss;
    cy = 0; ov = 0;
    if (op <= 18) begin
      ci = c;
      case (op)
        0:  begin x = a;     y = b;     end
        1:  begin x = a;     y = M - b; end
        2:  begin x = M - a; y = b;     end
        3:  begin x = a;     y = 0;     end
        4:  begin x = b;     y = 0;     end
        5:  begin x = M - a; y = 0;     end
        6:  begin x = M - b; y = 0;     end
        7:  begin x = a;     y = a;     end
        8:  begin x = b;     y = b;     end
        9:  begin x = a;     y = M;     end
        10: begin x = b;     y = M;     end
        11: begin x = M - a; y = M - b; end
        12: begin x = a;     y = M - b; ci = 1; end
        13: begin x = M - a; y = b;     ci = 1; end
        14: begin x = a;     y = b;     ci = 0; end
        15: begin x = 0;     y = 0;     ci = 0; end
        16: begin x = a;     y = 0;     ci = 1; end
        17: begin x = b;     y = 0;     ci = 1; end
        default: begin x = M - a; y = 0; ci = 1; end
      endcase
      s   = x + y + ci;
      res = s % (M + 1);
      cy  = s / (M + 1);
      ss  = sgn(x) + sgn(y) + ci;
      ov  = (ss > (M >> 1) || ss < -((M + 1) >> 1)) ? 1 : 0;
    end else begin
      case (op)
        19: res = a & b;
        20: res = a | b;
        21: res = a ^ b;
        22: res = M - (a ^ b);
        23: res = M - (a & b);
        24: res = M - (a | b);
        25: res = M - a;
        26: res = M - b;
        27: res = a;
        28: res = b;
        29: res = M;
        30: res = 0;
        default: res = a & (M - b);
      endcase
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r, cy, ov;
    // R1: reset state
    tick(); tick();
    chk("R1", "result after reset", resOut, 0);
    chk("R1", "zero after reset", zeroFlag, 1);
    chk("R1", "flags after reset", {negFlag, carryOut, ovfFlag}, 0);
    rst = 1'b0;
    tick();

    // R5 R7 R8 R9 R10: exhaustive sweep with both bypasses
    passOperands = 1'b1; passResult = 1'b1;
    for (int op = 0; op < 32; op++)
      for (int a = 0; a <= M; a++)
        for (int b = 0; b <= M; b++)
          for (int c = 0; c < 2; c++) begin
            fnSel = op[4:0]; aIn = a[W-1:0]; bIn = b[W-1:0]; carryIn = c[0];
            #1;
            model(op, a, b, c, r, cy, ov);
            if (op <= 18) begin
              chk("R7", "arith result", resOut, r);
              chk("R8", "carry/ovf/sign", {carryOut, ovfFlag, negFlag}, {cy[0], ov[0], r[W-1]});
            end else begin
              chk("R9", "logic result", resOut, r);
              chk("R9", "carry/ovf/sign", {carryOut, ovfFlag, negFlag}, {2'b00, r[W-1]});
            end
            chk("R10", "zero flag", zeroFlag, (r == 0) ? 1 : 0);
          end

    // R12: 8-bit sum 0xB7 + 0x5C from two slices
    fnSel = 5'h00; aIn = 4'h7; bIn = 4'hC; carryIn = 1'b0; #1;
    chk("R12", "low slice", {carryOut, resOut}, 5'h13);
    cy = carryOut;
    aIn = 4'hB; bIn = 4'h5; carryIn = cy[0]; #1;
    chk("R12", "high slice", {carryOut, resOut}, 5'h11);

    // R3: bypassed operands act without a clock edge
    aIn = 4'd2; bIn = 4'd3; carryIn = 1'b0; #1;
    chk("R3", "bypass same cycle", resOut, 5);

    // R2: shared bus fills A then B, then holds
    passOperands = 1'b0;
    aIn = 4'd5; bIn = 4'd5; loadAN = 1'b0; tick();
    loadAN = 1'b1; aIn = 4'd6; bIn = 4'd6; loadBN = 1'b0; tick();
    loadBN = 1'b1; aIn = 4'd9; bIn = 4'd9; #1;
    chk("R2", "A then B from one bus", resOut, 11);
    tick();
    chk("R2", "operands held", resOut, 11);

    // R4: result register load then hold
    passOperands = 1'b1; passResult = 1'b0;
    aIn = 4'd7; bIn = 4'd7; carryIn = 1'b1; loadFN = 1'b0; tick();
    chk("R4", "loaded result", resOut, 15);
    chk("R4", "loaded ovf", ovfFlag, 1);
    loadFN = 1'b1; aIn = 4'd1; bIn = 4'd1; carryIn = 1'b0; tick();
    chk("R4", "held result", resOut, 15);
    chk("R4", "held ovf", ovfFlag, 1);

    // R6: accumulation through A feedback
    rst = 1'b1; tick(); rst = 1'b0;
    passOperands = 1'b0; bIn = 4'd3; loadBN = 1'b0; tick();
    loadBN = 1'b1; fbToA = 1'b1; loadFN = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk("R6", "accumulate 5x3", resOut, 15);
    tick();
    chk("R6", "accumulate wrap", {carryOut, resOut}, 5'h12);
    fbToB = 1'b1; tick();
    chk("R6", "both fed back doubles", resOut, 4);
    fbToA = 1'b0; fnSel = 5'h02; tick();
    chk("R6", "B fed back, ~A+B", {carryOut, resOut}, 5'h13);
    loadFN = 1'b1; fbToB = 1'b0;

    // R11: output gating
    outEn = 1'b0; #1;
    chk("R11", "gated bus", resOut, 0);
    chk("R11", "flags kept", {zeroFlag, carryOut}, 2'b01);
    outEn = 1'b1; #1;
    chk("R11", "bus restored", resOut, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule